// File: doc/BRIEF.md
# Access Command Clock-Domain Bridge

This block moves memory access commands from the clock domain of a requesting driver into the clock domain of a memory controller, and sends the controller's completion status back. On the driver side it accepts a one-cycle start pulse, a write/read select, a start address, a word count and a one-cycle write-flush pulse. It returns a done level. On the controller side it presents the same command, aligned to the controller clock.

The two pulses each cross through a toggle synchronizer. The driver toggles a flag, the controller samples the flag through a short flop chain, and an edge detector turns each change back into a one-cycle pulse. The write/read select is held in a controller-side register that loads on the regenerated start pulse. Address and count pass unsynchronized, because the driver holds them steady for the whole access. The done level travels back through a flop chain that resets to high, which means idle. When the parameter `CROSS_EN` is 0, both sides are assumed to run on one clock and every output is a plain wire copy of its input.

Top module: `xb_cmd_bridge`

## Requirements
- R1: With `CROSS_EN`=1, each one-cycle `drv_start` pulse produces exactly one `ctl_start` pulse. That pulse is high for exactly one `ctl_clk` cycle and appears within `SYNC_STAGES`+1 controller cycles.
- R2: With `CROSS_EN`=1, each one-cycle `drv_flush` pulse produces exactly one one-cycle `ctl_flush` pulse. The flush path never causes a `ctl_start` pulse, and the start path never causes a `ctl_flush` pulse.
- R3: With `CROSS_EN`=1, `ctl_is_write` shows the value of `drv_is_write` (1 = write, 0 = read) in the cycle where `ctl_start` is high. It then holds that value until the next `ctl_start`, whatever `drv_is_write` does in the meantime.
- R4: `ctl_addr` and `ctl_len` are unregistered copies of `drv_addr` and `drv_len`.
- R5: With `CROSS_EN`=1, `drv_done` follows the level of `ctl_done` after `SYNC_STAGES` `drv_clk` flops. This applies to both the falling edge and the rising edge.
- R6: After reset, `drv_done` is 1, `ctl_start` and `ctl_flush` are 0, and `ctl_is_write` is 0.
- R7: With `CROSS_EN`=0, `ctl_start`, `ctl_flush`, `ctl_is_write` and `drv_done` are combinational copies of `drv_start`, `drv_flush`, `drv_is_write` and `ctl_done`, valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drv_clk | input | 1 | Driver-side clock |
| drv_rst_n | input | 1 | Driver-side synchronous reset, active low |
| drv_start | input | 1 | One-cycle pulse that starts an access |
| drv_is_write | input | 1 | 1 = write access, 0 = read access |
| drv_addr | input | ADDR_W | Start address, held stable during an access |
| drv_len | input | LEN_W | Word count, held stable during an access |
| drv_flush | input | 1 | One-cycle pulse requesting a write flush |
| drv_done | output | 1 | Completion level, synchronized into the driver clock |
| ctl_clk | input | 1 | Controller-side clock |
| ctl_rst_n | input | 1 | Controller-side synchronous reset, active low |
| ctl_start | output | 1 | Regenerated one-cycle start pulse |
| ctl_is_write | output | 1 | Write/read select, held for the current access |
| ctl_addr | output | ADDR_W | Start address, passed straight through |
| ctl_len | output | LEN_W | Word count, passed straight through |
| ctl_flush | output | 1 | Regenerated one-cycle flush pulse |
| ctl_done | input | 1 | Completion level from the controller |

## Verification
On every cycle, the assertions check three things: that each regenerated pulse lasts one controller cycle, that the write/read select stays unchanged between start pulses, and that done reads idle on the first driver cycle after reset. Only the bench scenarios can show the end-to-end results. These are: one controller pulse per driver pulse over a long train at two unrelated clock rates, no crosstalk between the start and flush paths, the round trip of the done level in both directions, and the same-cycle wire behaviour when crossing is disabled.

// File: rtl/xb_pkg.sv
// Package: shared constants for the command bridge.
// Assumes: at least two synchronizer stages are always used.
package xb_pkg;
    localparam int XB_MIN_STAGES = 2;
    localparam int XB_DEF_STAGES = 2;

    // Purpose: clamp a requested stage count to the safe minimum.
    function automatic int xb_stages(input int req);
        return (req < XB_MIN_STAGES) ? XB_MIN_STAGES : req;
    endfunction
endpackage

// File: rtl/xb_pulse_xing.sv
// Module: carries one-cycle pulses from the source clock to the destination clock
// using a toggle flag, a flop chain and an edge detector.
// Assumes: source pulses are spaced further apart than STAGES+1 destination cycles.
module xb_pulse_xing #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              src_tog;
    logic [STAGES-1:0] dst_chain;
    logic              dst_last;

    // Purpose: flip the flag once for every source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     src_tog <= 1'b0;
        else if (src_pulse) src_tog <= ~src_tog;
    end

    // Purpose: resample the flag and remember its previous settled value.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            dst_chain <= '0;
            dst_last  <= 1'b0;
        end else begin
            dst_chain <= {dst_chain[STAGES-2:0], src_tog};
            dst_last  <= dst_chain[STAGES-1];
        end
    end

    assign dst_pulse = dst_chain[STAGES-1] ^ dst_last;
endmodule

// File: rtl/xb_level_sync.sv
// Module: flop-chain synchronizer for a slowly changing level.
// Assumes: the input holds each value for several destination cycles.
module xb_level_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the level through the chain; reset to the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/xb_cmd_capture.sv
// Module: holds a quasi-static command bit in the destination clock domain.
// It loads when the regenerated start pulse is high, and passes the input
// straight through during that same cycle.
// Assumes: din is stable from before the source pulse until after the load.
module xb_cmd_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic din,
    output logic dout
);
    logic held;

    // Purpose: load the command bit on the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= 1'b0;
        else if (take) held <= din;
    end

    assign dout = take ? din : held;
endmodule

// File: rtl/xb_cmd_bridge.sv
// Module: command bridge between the driver and memory-controller clock domains.
// Pulses cross with toggle synchronizers, done returns through a flop chain,
// and address and count pass unsynchronized.
// Assumes: drv_addr, drv_len and drv_is_write stay stable for the whole access.
// With CROSS_EN=0, both clocks must be the same clock.
module xb_cmd_bridge
    import xb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter bit CROSS_EN    = 1'b1,
    parameter int SYNC_STAGES = XB_DEF_STAGES
) (
    input  logic              drv_clk,
    input  logic              drv_rst_n,
    input  logic              drv_start,
    input  logic              drv_is_write,
    input  logic [ADDR_W-1:0] drv_addr,
    input  logic [LEN_W-1:0]  drv_len,
    input  logic              drv_flush,
    output logic              drv_done,
    input  logic              ctl_clk,
    input  logic              ctl_rst_n,
    output logic              ctl_start,
    output logic              ctl_is_write,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [LEN_W-1:0]  ctl_len,
    output logic              ctl_flush,
    input  logic              ctl_done
);
    localparam int STG = xb_stages(SYNC_STAGES);

    // Purpose: quasi-static fields cross as plain wires.
    assign ctl_addr = drv_addr;
    assign ctl_len  = drv_len;

    if (CROSS_EN) begin : g_cross
        xb_pulse_xing #(.STAGES(STG)) u_start_x (
            .src_clk(drv_clk), .src_rst_n(drv_rst_n), .src_pulse(drv_start),
            .dst_clk(ctl_clk), .dst_rst_n(ctl_rst_n), .dst_pulse(ctl_start)
        );
        xb_pulse_xing #(.STAGES(STG)) u_flush_x (
            .src_clk(drv_clk), .src_rst_n(drv_rst_n), .src_pulse(drv_flush),
            .dst_clk(ctl_clk), .dst_rst_n(ctl_rst_n), .dst_pulse(ctl_flush)
        );
        xb_cmd_capture u_wnr (
            .clk(ctl_clk), .rst_n(ctl_rst_n), .take(ctl_start),
            .din(drv_is_write), .dout(ctl_is_write)
        );
        xb_level_sync #(.STAGES(STG), .RST_VAL(1'b1)) u_done_s (
            .clk(drv_clk), .rst_n(drv_rst_n), .din(ctl_done), .dout(drv_done)
        );
    end else begin : g_wire
        assign ctl_start    = drv_start;
        assign ctl_flush    = drv_flush;
        assign ctl_is_write = drv_is_write;
        assign drv_done     = ctl_done;
    end
endmodule

// File: rtl/xb_cmd_bridge_chk.sv
// Module: assertion checker for the command bridge, attached with bind.
// Assumes: only the crossing variant runs on unrelated clocks.
module xb_cmd_bridge_chk #(
    parameter bit CROSS_EN = 1'b1
) (
    input logic drv_clk,
    input logic drv_rst_n,
    input logic drv_done,
    input logic ctl_clk,
    input logic ctl_rst_n,
    input logic ctl_start,
    input logic ctl_flush,
    input logic ctl_is_write
);
    if (CROSS_EN) begin : g_chk
        AST_START_ONE_CYCLE: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
            ctl_start |=> !ctl_start); // R1
        AST_FLUSH_ONE_CYCLE: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
            ctl_flush |=> !ctl_flush); // R2
        AST_WNR_HELD: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
            (!ctl_start && !$past(ctl_start)) |-> $stable(ctl_is_write)); // R3
        AST_DONE_IDLE_AFTER_RST: assert property (@(posedge drv_clk) disable iff (!drv_rst_n)
            !$past(drv_rst_n) |-> drv_done); // R6
    end
endmodule

bind xb_cmd_bridge xb_cmd_bridge_chk #(.CROSS_EN(CROSS_EN)) u_chk (
    .drv_clk(drv_clk), .drv_rst_n(drv_rst_n), .drv_done(drv_done),
    .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_start(ctl_start),
    .ctl_flush(ctl_flush), .ctl_is_write(ctl_is_write)
);

// File: tb/test_xb_cmd_bridge.sv
`timescale 1ns/100ps
module test_xb_cmd_bridge;
    logic drv_clk = 1'b0, ctl_clk = 1'b0;
    logic drv_rst_n = 1'b0, ctl_rst_n = 1'b0;
    logic drv_start = 1'b0, drv_is_write = 1'b0, drv_flush = 1'b0, ctl_done = 1'b1;
    logic [31:0] drv_addr = '0;
    logic [15:0] drv_len = '0;
    logic drv_done, ctl_start, ctl_is_write, ctl_flush;
    logic [31:0] ctl_addr;
    logic [15:0] ctl_len;

    // Second instance: crossing disabled, both sides on drv_clk.
    logic w_start = 1'b0, w_wr = 1'b0, w_flush = 1'b0, w_cdone = 1'b0;
    logic [31:0] w_addr = '0;
    logic [15:0] w_len = '0;
    logic w_ddone, w_cstart, w_cwr, w_cflush;
    logic [31:0] w_caddr;
    logic [15:0] w_clen;

    int n_vec = 0, n_bad = 0;
    int n_start = 0, n_flush = 0;
    logic        cap_wr;
    logic [31:0] cap_addr;
    logic [15:0] cap_len;
    bit finished = 1'b0;

    always #2.0 drv_clk = ~drv_clk;   // 250 MHz
    always #3.5 ctl_clk = ~ctl_clk;   // unrelated controller clock

    xb_cmd_bridge i_xb_cmd_bridge (
        .drv_clk(drv_clk), .drv_rst_n(drv_rst_n), .drv_start(drv_start),
        .drv_is_write(drv_is_write), .drv_addr(drv_addr), .drv_len(drv_len),
        .drv_flush(drv_flush), .drv_done(drv_done), .ctl_clk(ctl_clk),
        .ctl_rst_n(ctl_rst_n), .ctl_start(ctl_start), .ctl_is_write(ctl_is_write),
        .ctl_addr(ctl_addr), .ctl_len(ctl_len), .ctl_flush(ctl_flush), .ctl_done(ctl_done)
    );

    xb_cmd_bridge #(.CROSS_EN(1'b0)) i_xb_cmd_bridge_wire (
        .drv_clk(drv_clk), .drv_rst_n(drv_rst_n), .drv_start(w_start),
        .drv_is_write(w_wr), .drv_addr(w_addr), .drv_len(w_len),
        .drv_flush(w_flush), .drv_done(w_ddone), .ctl_clk(drv_clk),
        .ctl_rst_n(drv_rst_n), .ctl_start(w_cstart), .ctl_is_write(w_cwr),
        .ctl_addr(w_caddr), .ctl_len(w_clen), .ctl_flush(w_cflush), .ctl_done(w_cdone)
    );

    // Monitor: count and capture regenerated pulses mid-cycle.
    always @(negedge ctl_clk) begin
        if (ctl_rst_n && ctl_start) begin
            n_start++;
            cap_wr   = ctl_is_write;
            cap_addr = ctl_addr;
            cap_len  = ctl_len;
        end
        if (ctl_rst_n && ctl_flush) n_flush++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drv_wait(input int n);
        repeat (n) @(negedge drv_clk);
    endtask

    task automatic t_reset;
        drv_wait(2);
        chk(drv_done == 1'b1, "R6 done idle", drv_done, 1);
        chk(ctl_start == 1'b0, "R6 start low", ctl_start, 0);
        chk(ctl_flush == 1'b0, "R6 flush low", ctl_flush, 0);
        chk(ctl_is_write == 1'b0, "R6 select low", ctl_is_write, 0);
    endtask

    task automatic t_access(input bit wr, input logic [31:0] a, input logic [15:0] l);
        int s0 = n_start, f0 = n_flush;
        @(negedge drv_clk);
        drv_start = 1'b1; drv_is_write = wr; drv_addr = a; drv_len = l;
        @(negedge drv_clk);
        drv_start = 1'b0;
        drv_wait(12);
        chk(n_start == s0 + 1, "R1 one start pulse", n_start, s0 + 1);
        chk(n_flush == f0, "R2 no flush from start", n_flush, f0);
        chk(cap_wr == wr, "R3 select at pulse", cap_wr, wr);
        chk(cap_addr == a, "R4 address", cap_addr, a);
        chk(cap_len == l, "R4 count", cap_len, l);
        drv_is_write = ~wr;
        drv_wait(6);
        @(negedge ctl_clk); #0.5;
        chk(ctl_is_write == wr, "R3 select held", ctl_is_write, wr);
    endtask

    task automatic t_flush;
        int s0 = n_start, f0 = n_flush;
        @(negedge drv_clk); drv_flush = 1'b1;
        @(negedge drv_clk); drv_flush = 1'b0;
        drv_wait(12);
        chk(n_flush == f0 + 1, "R2 one flush pulse", n_flush, f0 + 1);
        chk(n_start == s0, "R2 no start from flush", n_start, s0);
    endtask

    task automatic t_done;
        @(negedge ctl_clk); ctl_done = 1'b0;
        drv_wait(1);
        chk(drv_done == 1'b1, "R5 done not early", drv_done, 1);
        drv_wait(4);
        chk(drv_done == 1'b0, "R5 done falls", drv_done, 0);
        @(negedge ctl_clk); ctl_done = 1'b1;
        drv_wait(5);
        chk(drv_done == 1'b1, "R5 done rises", drv_done, 1);
    endtask

    task automatic t_train;
        int s0 = n_start;
        for (int i = 0; i < 40; i++) begin
            @(negedge drv_clk);
            drv_start = 1'b1; drv_is_write = i[0]; drv_addr = 32'h1000 + i; drv_len = 16'(i + 1);
            @(negedge drv_clk);
            drv_start = 1'b0;
            drv_wait(7 + (i % 5));
        end
        drv_wait(12);
        chk(n_start == s0 + 40, "R1 pulse train count", n_start, s0 + 40);
        chk(cap_addr == 32'h1000 + 39, "R4 last address", cap_addr, 32'h1000 + 39);
        chk(cap_wr == 1'b1, "R3 last select", cap_wr, 1);
    endtask

    task automatic t_wire;
        @(negedge drv_clk);
        w_start = 1'b1; w_wr = 1'b1; w_addr = 32'hCAFE_0001; w_len = 16'd77; w_cdone = 1'b1;
        #0.5;
        chk(w_cstart == 1'b1, "R7 start same cycle", w_cstart, 1);
        chk(w_cwr == 1'b1, "R7 select wire", w_cwr, 1);
        chk(w_caddr == 32'hCAFE_0001, "R7 address wire", w_caddr, 32'hCAFE_0001);
        chk(w_ddone == 1'b1, "R7 done wire", w_ddone, 1);
        @(negedge drv_clk);
        w_start = 1'b0; w_flush = 1'b1; w_wr = 1'b0; w_cdone = 1'b0;
        #0.5;
        chk(w_cstart == 1'b0, "R7 start drops", w_cstart, 0);
        chk(w_cflush == 1'b1, "R7 flush wire", w_cflush, 1);
        chk(w_cwr == 1'b0, "R7 select follows", w_cwr, 0);
        chk(w_ddone == 1'b0, "R7 done follows", w_ddone, 0);
        @(negedge drv_clk); w_flush = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge drv_clk);
        drv_rst_n = 1'b1;
        @(negedge ctl_clk); ctl_rst_n = 1'b1;
        t_reset();
        t_access(1'b1, 32'h0000_0040, 16'd128);
        t_access(1'b0, 32'hFFFF_FFC0, 16'hFFFF);
        t_flush();
        t_done();
        t_train();
        t_flush();
        t_wire();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule